// File: doc/BRIEF.md
# Two-Channel PCM Auto-Mute Detector

This block sits in a two-channel signed PCM sample path, with one valid strobe per stereo frame. For each channel it counts the frames in a row that hold the same static value. A static value is all-zeros or all-ones (-1). When the run reaches a threshold, which is 8192 frames by default, the block replaces that channel's samples with zeros and raises that channel's mute-control flag. The first frame that carries any other value lifts the mute at once, and that frame passes through unchanged.

By default each channel decides for itself. A link input joins the two decisions. With the link set, both channels mute only when both have reached the threshold, and a non-static frame on either channel releases both. A disable input turns the feature off and clears the run counts. The input is active high, so auto-mute is on when the input is tied low. Mute is a hard substitution of zeros. It has no ramp and does not wait for a zero crossing.

Top module: `pcm_auto_mute`

## Requirements
- R1: A channel's `mute_*_o` goes to 1, and its output sample is 0, for the frame whose strobe completes a run of THRESH (default 8192) consecutive valid frames that all carry the same static value (all-zeros or all-ones). The outputs are registered, so they appear one clock after that strobe, together with `valid_o`.
- R2: A frame whose sample is neither all-zeros nor all-ones clears that channel's mute flag one clock after its strobe and appears unchanged at the output.
- R3: A static frame whose value differs from the previous static frame (0 then -1, or -1 then 0) restarts the run at a count of one.
- R4: With `link_i` = 0, the two channels count, mute and release independently.
- R5: With `link_i` = 1, both channels mute only when both runs are at the threshold, and a non-static frame on either channel releases both channels.
- R6: While `amute_off_i` = 1, no channel mutes and the run counts are held at zero. After the input returns to 0, a channel needs a full new run of THRESH frames before it mutes.
- R7: Every output sample that is produced while its channel is muted is zero.
- R8: After reset, `valid_o`, both mute flags and both output samples are 0.
- R9: `valid_o` repeats `valid_i` one clock later. On clocks with no input strobe, the output samples and mute flags hold their values and the run counts do not change.
- R10: The run count saturates at the threshold, so a static run of any length past THRESH keeps the channel muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Frame strobe for both input samples |
| amute_off_i | input | 1 | 1 disables auto-mute and clears the run counts |
| link_i | input | 1 | 1 makes the mute decision joint across both channels |
| smp_a_i | input | W | Channel A signed input sample |
| smp_b_i | input | W | Channel B signed input sample |
| valid_o | output | 1 | Output frame strobe |
| smp_a_o | output | W | Channel A output sample, zero while muted |
| smp_b_o | output | W | Channel B output sample, zero while muted |
| mute_a_o | output | 1 | Channel A mute-control flag |
| mute_b_o | output | 1 | Channel B mute-control flag |

## Verification
The case that is hardest to reach from the ports is the exact threshold frame. Reaching it takes thousands of uninterrupted identical frames, with idle gaps between strobes that must not count. The stimulus sends runs counted in valid frames, with random gaps, so the run crosses the threshold at an arbitrary clock. It also sends near-complete runs that are broken by a 0/-1 swap, and it sends linked runs in which only one channel is static. A reference model tracks each run and is compared with the outputs on every clock.

// File: rtl/pcm_amute_pkg.sv
package pcm_amute_pkg;
  typedef enum logic {
    LVL_ZERO = 1'b0,
    LVL_ONES = 1'b1
  } lvl_e;
endpackage

// File: rtl/amute_run_counter.sv
module amute_run_counter
  import pcm_amute_pkg::*;
#(
  parameter int W      = 16,
  parameter int THRESH = 8192
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         clr_i,
  input  logic [W-1:0] smp_i,
  output logic         reached_o
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(THRESH);

  logic          is_zero, is_ones, is_static;
  lvl_e          lvl_cur, lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign is_zero   = (smp_i == '0);
  assign is_ones   = &smp_i;
  assign is_static = is_zero | is_ones;
  assign lvl_cur   = is_ones ? LVL_ONES : LVL_ZERO;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (valid_i) begin
      if (is_static) begin
        lvl_d = lvl_cur;
        if (cnt_q != '0 && lvl_cur != lvl_q) cnt_d = CW'(1);
        else if (cnt_q != CNT_MAX)           cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= LVL_ZERO;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign reached_o = (cnt_d == CNT_MAX);

  assert_cnt_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  assert_swap_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && valid_i && is_static && cnt_q != '0 && lvl_cur != lvl_q) |=> cnt_q == CW'(1));

  assert_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/amute_link_ctrl.sv
module amute_link_ctrl #(
  parameter int NCH = 2
) (
  input  logic           link_i,
  input  logic [NCH-1:0] reached_i,
  output logic [NCH-1:0] mute_req_o
);
  logic all_reached;
  assign all_reached = &reached_i;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      mute_req_o[c] = link_i ? all_reached : reached_i[c];
  end

  always_comb begin
    if (link_i)
      assert_link_equal_R5: assert ($countones(mute_req_o) == 0 || $countones(mute_req_o) == NCH);
  end
endmodule

// File: rtl/amute_out_stage.sv
module amute_out_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         mute_i,
  input  logic [W-1:0] smp_i,
  output logic [W-1:0] smp_o,
  output logic         mute_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o  <= '0;
      mute_o <= 1'b0;
    end else if (valid_i) begin
      smp_o  <= mute_i ? '0 : smp_i;
      mute_o <= mute_i;
    end
  end

  assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(smp_o) && $stable(mute_o)));

  assert_mute_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mute_i) |=> (smp_o == '0 && mute_o));
endmodule

// File: rtl/pcm_auto_mute.sv
module pcm_auto_mute #(
  parameter int W      = 16,
  parameter int THRESH = 8192
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         amute_off_i,
  input  logic         link_i,
  input  logic [W-1:0] smp_a_i,
  input  logic [W-1:0] smp_b_i,
  output logic         valid_o,
  output logic [W-1:0] smp_a_o,
  output logic [W-1:0] smp_b_o,
  output logic         mute_a_o,
  output logic         mute_b_o
);
  localparam int NCH = 2;

  logic [W-1:0]   smp_in  [NCH];
  logic [W-1:0]   smp_out [NCH];
  logic [NCH-1:0] reached, mute_req, mute_out;

  assign smp_in[0] = smp_a_i;
  assign smp_in[1] = smp_b_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    amute_run_counter #(.W(W), .THRESH(THRESH)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (valid_i),
      .clr_i    (amute_off_i),
      .smp_i    (smp_in[c]),
      .reached_o(reached[c])
    );

    amute_out_stage #(.W(W)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(valid_i),
      .mute_i (mute_req[c]),
      .smp_i  (smp_in[c]),
      .smp_o  (smp_out[c]),
      .mute_o (mute_out[c])
    );
  end

  amute_link_ctrl #(.NCH(NCH)) u_link (
    .link_i    (link_i),
    .reached_i (reached),
    .mute_req_o(mute_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign smp_a_o  = smp_out[0];
  assign smp_b_o  = smp_out[1];
  assign mute_a_o = mute_out[0];
  assign mute_b_o = mute_out[1];

  logic dyn_a, dyn_b;
  assign dyn_a = !(smp_a_i == '0 || &smp_a_i);
  assign dyn_b = !(smp_b_i == '0 || &smp_b_i);

  assert_release_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dyn_a) |=> (!mute_a_o && smp_a_o == $past(smp_a_i)));

  assert_release_b_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dyn_b) |=> (!mute_b_o && smp_b_o == $past(smp_b_i)));

  assert_link_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && link_i && (dyn_a || dyn_b)) |=> (!mute_a_o && !mute_b_o));

  assert_link_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && link_i) |=> (mute_a_o == mute_b_o));

  assert_off_no_mute_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amute_off_i) |=> (!mute_a_o && !mute_b_o));

  assert_valid_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
endmodule

// File: tb/pcm_auto_mute_tb.sv
module pcm_auto_mute_tb;
  localparam int W  = 16;
  localparam int TH = 8192;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, off = 1'b0, link = 1'b0;
  logic [W-1:0] sa = '0, sb = '0;
  logic valid_o, mute_a, mute_b;
  logic [W-1:0] oa, ob;

  always #5 clk = ~clk;

  pcm_auto_mute #(.W(W), .THRESH(TH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .amute_off_i(off), .link_i(link),
    .smp_a_i(sa), .smp_b_i(sb), .valid_o(valid_o), .smp_a_o(oa), .smp_b_o(ob),
    .mute_a_o(mute_a), .mute_b_o(mute_b));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R8";

  // reference model
  int run [2];
  logic [W-1:0] last [2];
  logic e_valid, e_ma, e_mb;
  logic [W-1:0] e_a, e_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run[0] = 0; run[1] = 0; last[0] = '0; last[1] = '0;
      e_valid = 0; e_ma = 0; e_mb = 0; e_a = '0; e_b = '0;
    end else begin
      logic [W-1:0] s [2];
      bit r [2];
      s[0] = sa; s[1] = sb;
      e_valid = valid;
      for (int c = 0; c < 2; c++) begin
        if (off) run[c] = 0;
        else if (valid) begin
          if (s[c] == '0 || s[c] == ONES) begin
            if (run[c] > 0 && s[c] != last[c]) run[c] = 1;
            else if (run[c] < TH) run[c] = run[c] + 1;
            last[c] = s[c];
          end else run[c] = 0;
        end
        r[c] = (run[c] == TH);
      end
      if (valid) begin
        if (link) begin e_ma = r[0] && r[1]; e_mb = e_ma; end
        else begin e_ma = r[0]; e_mb = r[1]; end
        e_a = e_ma ? '0 : s[0];
        e_b = e_mb ? '0 : s[1];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(valid_o == e_valid, cur_req, "valid_o", valid_o, e_valid);
    chk(mute_a == e_ma, cur_req, "mute_a", mute_a, e_ma);
    chk(mute_b == e_mb, cur_req, "mute_b", mute_b, e_mb);
    chk(oa == e_a, cur_req, "smp_a", oa, e_a);
    chk(ob == e_b, cur_req, "smp_b", ob, e_b);
  end

  function automatic logic [W-1:0] noise();
    logic [W-1:0] v;
    do v = W'($urandom); while (v == '0 || v == ONES);
    return v;
  endfunction

  // kind: 0 zeros, 1 ones, 2 noise
  function automatic logic [W-1:0] pick(int kind);
    return kind == 0 ? '0 : (kind == 1 ? ONES : noise());
  endfunction

  task automatic frames(int n, int ka, int kb);
    int sent = 0;
    while (sent < n) begin
      @(negedge clk);
      if ($urandom_range(0, 4) == 0) valid = 1'b0;
      else begin
        valid = 1'b1; sa = pick(ka); sb = pick(kb); sent++;
      end
    end
    @(negedge clk); valid = 1'b0;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(valid_o == 0 && mute_a == 0 && mute_b == 0, "R8", "reset flags", {valid_o, mute_a, mute_b}, 0);
    chk(oa == 0 && ob == 0, "R8", "reset samples", {oa, ob}, 0);
    rst_n = 1'b1;

    cur_req = "R1";
    frames(TH - 1, 0, 2);
    chk(mute_a == 0, "R1", "one short of threshold", mute_a, 0);
    frames(1, 0, 2);
    chk(mute_a == 1 && oa == 0, "R1", "threshold mute", mute_a, 1);
    chk(mute_b == 0, "R4", "other channel unmuted", mute_b, 0);

    cur_req = "R10";
    frames(3000, 0, 2);
    chk(mute_a == 1, "R10", "saturated run stays muted", mute_a, 1);

    cur_req = "R2";
    frames(1, 2, 2);
    chk(mute_a == 0 && oa != 0, "R2", "non-static release", mute_a, 0);

    cur_req = "R3";
    frames(5000, 0, 2);
    frames(TH - 1, 1, 2);
    chk(mute_a == 0, "R3", "swap restarts run", mute_a, 0);
    frames(1, 1, 2);
    chk(mute_a == 1, "R3", "full run after swap", mute_a, 1);

    cur_req = "R4";
    frames(TH, 2, 1);
    chk(mute_b == 1 && mute_a == 0, "R4", "independent B mute", {mute_a, mute_b}, 1);
    chk(ob == 0, "R7", "muted B sample zero", ob, 0);

    cur_req = "R5";
    link = 1'b1;
    frames(TH + 10, 0, 2);
    chk(mute_a == 0 && mute_b == 0, "R5", "linked one-sided no mute", {mute_a, mute_b}, 0);
    frames(TH, 0, 1);
    chk(mute_a == 1 && mute_b == 1, "R5", "linked both mute", {mute_a, mute_b}, 3);
    chk(oa == 0 && ob == 0, "R7", "linked muted zeros", {oa, ob}, 0);
    frames(1, 0, 2);
    chk(mute_a == 0 && mute_b == 0, "R5", "linked release by B", {mute_a, mute_b}, 0);
    link = 1'b0;

    cur_req = "R6";
    frames(TH - 5, 0, 0);
    off = 1'b1;
    frames(20, 0, 0);
    chk(mute_a == 0 && mute_b == 0, "R6", "disabled no mute", {mute_a, mute_b}, 0);
    off = 1'b0;
    frames(TH - 1, 0, 0);
    chk(mute_a == 0, "R6", "fresh run needed", mute_a, 0);
    frames(1, 0, 0);
    chk(mute_a == 1 && mute_b == 1, "R6", "mute after re-enable", {mute_a, mute_b}, 3);

    cur_req = "R9";
    repeat (5) @(negedge clk);
    chk(valid_o == 0 && mute_a == 1 && oa == 0, "R9", "idle hold", {valid_o, mute_a}, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule